// File: doc/BRIEF.md
# Paged Scratch-RAM Window Controller

This block sits on a CPU byte bus and holds a private 2048-byte scratch RAM. The CPU cannot see the whole RAM at once. It sees a 32-byte window, and an internal page pointer places that window anywhere in the RAM in steps of 32 bytes. The CPU can access the window in place. It can also access it with auto-advance, where the access completes at the current page and the pointer then moves forward one page. A separate access returns the pointer to page zero. Software can therefore stream through the full RAM with one fixed address.

The same decoded space carries a few control bits for a floppy subsystem. These are a head-select line, a 3.5-inch drive select, and an internal-drive enable. Strobe offsets set or clear these bits. A write strobe also sends a one-cycle reset pulse to the attached disk controller. The disk controller asks for a drive on a small request input. The block gates that request into a drive-enable output.

The block answers only while a ROM-switch input is high, and only in two 256-byte slices of its 2 KB bus region. When the ROM-switch input is low, the page pointer, the 3.5-inch select and the internal-drive enable are held cleared.

Top module: `scratch_window_ctrl`

## Requirements
- R1: A synchronous active-high reset clears busRdata, diskReset, hdSel, sel35, intDrive and the page pointer. driveEnable is therefore low after reset.
- R2: A read or write at bus offset 0x200–0x21F reaches RAM byte (page*32 + offset[4:0]) and leaves the page pointer unchanged. A read's byte appears on busRdata in the cycle after the clock edge that captured it, and stays there until the next read.
- R3: An access at offset 0x220–0x23F first reads or writes at the current page. The page pointer then moves up by one 32-byte page, and page 63 wraps to page 0.
- R4: A read or a write at offset 0x2A0 sets the page pointer to page 0.
- R5: A read at offset 0x240–0x25F clears hdSel, and a read at 0x260–0x27F sets it. A write at 0x240–0x25F clears sel35, and a write at 0x260–0x27F sets it. No other access changes hdSel.
- R6: A write at offset 0x040 drives diskReset high for exactly the one cycle that follows the capturing edge.
- R7: A write at offset 0x080–0x09F sets intDrive, and a write at 0x0C0–0x0DF clears it.
- R8: The offset is the bus address minus 0x400. The bus addresses 0x400–0x4FF and 0x600–0x6FF are decoded, and only while romSwitch and busSel are high. An access at any other address has no effect on the RAM, the page pointer or the control bits. A read there returns 0x00.
- R9: At every clock edge where romSwitch is low, the page pointer, sel35 and intDrive clear. hdSel and the RAM contents keep their values.
- R10: driveEnable is high in the same cycle only when sel35 is 1, intDrive is 1 and enableReq equals 2. In every other case it is low.
- R11: A read at a decoded offset outside the two window ranges returns 0x00. Reset does not clear the RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| romSwitch | input | 1 | Decode enable; while low, the pointer and the drive bits clear |
| busSel | input | 1 | Chip select for the 2 KB bus region |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe (wins over busRd) |
| busAddr | input | 11 | Byte address inside the 2 KB region |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| enableReq | input | 2 | Drive-enable request from the disk controller |
| diskReset | output | 1 | One-cycle disk-controller reset pulse |
| hdSel | output | 1 | Head-select line |
| sel35 | output | 1 | 3.5-inch drive select |
| intDrive | output | 1 | Internal-drive enable |
| driveEnable | output | 1 | Gated drive-enable output |

## Verification
Read data, hdSel, sel35, intDrive and the page pointer are all registered. Each is due in the cycle after the edge that captured the access. diskReset is high in that same following cycle and low again one cycle later. driveEnable is combinational, so it follows enableReq in the same cycle. The bench drives inputs just after a rising edge, lets one edge capture them, and returns the bus to idle before the next edge. It then samples on the falling edge, so that each directed check and the per-cycle model comparison look at exactly the cycle in which a result is due.

// File: rtl/swc_pkg.sv
package swc_pkg;

  localparam int SwcAddrW = 11;
  localparam int SwcOfsW  = 10;

  // strobes toward the RAM/page datapath
  typedef struct packed {
    logic wr;
    logic rd;
    logic zero;
    logic advance;
    logic pageClr;
  } ramStrobe_t;

  // strobes toward the control-bit register file
  typedef struct packed {
    logic hdSet;
    logic hdClr;
    logic s35Set;
    logic s35Clr;
    logic intSet;
    logic intClr;
    logic fdcRst;
  } ctlStrobe_t;

endpackage

// File: rtl/swc_decode.sv
module swc_decode
  import swc_pkg::*;
#(
  parameter int WIN_BYTES = 32,
  localparam int WIN_W = $clog2(WIN_BYTES)
) (
  input  logic                busSel,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [SwcAddrW-1:0] busAddr,
  input  logic                romSwitch,
  output ramStrobe_t          ramStb,
  output ctlStrobe_t          ctlStb,
  output logic [WIN_W-1:0]    winOfs
);

  localparam logic [SwcOfsW-WIN_W-1:0] BlkDirect = 5'h10;  // 0x200
  localparam logic [SwcOfsW-WIN_W-1:0] BlkAdv    = 5'h11;  // 0x220
  localparam logic [SwcOfsW-WIN_W-1:0] BlkLow    = 5'h12;  // 0x240
  localparam logic [SwcOfsW-WIN_W-1:0] BlkHigh   = 5'h13;  // 0x260
  localparam logic [SwcOfsW-WIN_W-1:0] BlkIntOn  = 5'h04;  // 0x080
  localparam logic [SwcOfsW-WIN_W-1:0] BlkIntOff = 5'h06;  // 0x0C0
  localparam logic [SwcOfsW-1:0]       OfsPgRst  = 10'h2A0;
  localparam logic [SwcOfsW-1:0]       OfsFdcRst = 10'h040;

  logic                        inRange;
  logic                        hit;
  logic                        wrHit;
  logic                        rdHit;
  logic                        anyRd;
  logic [SwcOfsW-1:0]          ofs;
  logic [SwcOfsW-WIN_W-1:0]    blk;
  logic                        inWin;

  // 0x400-0x4FF and 0x600-0x6FF: bit10 set, bit8 clear; offset = addr - 0x400
  assign inRange = busAddr[10] & ~busAddr[8];
  assign ofs     = {busAddr[9], 1'b0, busAddr[7:0]};
  assign blk     = ofs[SwcOfsW-1:WIN_W];
  assign winOfs  = ofs[WIN_W-1:0];

  assign hit   = busSel & romSwitch & inRange;
  assign wrHit = hit & busWr;
  assign rdHit = hit & busRd & ~busWr;
  assign anyRd = busSel & busRd & ~busWr;
  assign inWin = (blk == BlkDirect) | (blk == BlkAdv);

  always_comb begin
    ramStb         = '0;
    ramStb.wr      = wrHit & inWin;
    ramStb.rd      = rdHit & inWin;
    ramStb.zero    = anyRd & ~(rdHit & inWin);
    ramStb.advance = (wrHit | rdHit) & (blk == BlkAdv);
    ramStb.pageClr = (wrHit | rdHit) & (ofs == OfsPgRst);
  end

  always_comb begin
    ctlStb        = '0;
    ctlStb.hdClr  = rdHit & (blk == BlkLow);
    ctlStb.hdSet  = rdHit & (blk == BlkHigh);
    ctlStb.s35Clr = wrHit & (blk == BlkLow);
    ctlStb.s35Set = wrHit & (blk == BlkHigh);
    ctlStb.intSet = wrHit & (blk == BlkIntOn);
    ctlStb.intClr = wrHit & (blk == BlkIntOff);
    ctlStb.fdcRst = wrHit & (ofs == OfsFdcRst);
  end

endmodule

// File: rtl/swc_datapath.sv
module swc_datapath
  import swc_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  parameter int WIN_BYTES = 32,
  localparam int WIN_W  = $clog2(WIN_BYTES),
  localparam int PAGE_W = $clog2(RAM_BYTES / WIN_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             romSwitch,
  input  ramStrobe_t       ramStb,
  input  logic [WIN_W-1:0] winOfs,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData
);

  logic [7:0]              mem [RAM_BYTES];
  logic [PAGE_W-1:0]       pageIdx;
  logic [PAGE_W+WIN_W-1:0] ramAddr;

  // page base is always a multiple of the window, so concatenation adds
  assign ramAddr = {pageIdx, winOfs};

  // storage: never reset
  always_ff @(posedge clk) begin
    if (ramStb.wr) mem[ramAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (ramStb.rd) begin
      rdData <= mem[ramAddr];
    end else if (ramStb.zero) begin
      rdData <= '0;
    end
  end

  // advance uses the old page for this access; wrap is the natural overflow
  always_ff @(posedge clk) begin
    if (rst || !romSwitch) begin
      pageIdx <= '0;
    end else if (ramStb.pageClr) begin
      pageIdx <= '0;
    end else if (ramStb.advance) begin
      pageIdx <= pageIdx + 1'b1;
    end
  end

endmodule

// File: rtl/swc_ctlbits.sv
module swc_ctlbits
  import swc_pkg::*;
#(
  parameter int REQ_W = 2,
  parameter int DRIVE_SEL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             romSwitch,
  input  ctlStrobe_t       ctlStb,
  input  logic [REQ_W-1:0] enableReq,
  output logic             hdSel,
  output logic             sel35,
  output logic             intDrive,
  output logic             diskReset,
  output logic             driveEnable
);

  localparam logic [REQ_W-1:0] ReqMatch = REQ_W'(DRIVE_SEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      hdSel <= 1'b0;
    end else if (ctlStb.hdSet) begin
      hdSel <= 1'b1;
    end else if (ctlStb.hdClr) begin
      hdSel <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !romSwitch) begin
      sel35    <= 1'b0;
      intDrive <= 1'b0;
    end else begin
      if (ctlStb.s35Set)      sel35 <= 1'b1;
      else if (ctlStb.s35Clr) sel35 <= 1'b0;
      if (ctlStb.intSet)      intDrive <= 1'b1;
      else if (ctlStb.intClr) intDrive <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) diskReset <= 1'b0;
    else     diskReset <= ctlStb.fdcRst;
  end

  assign driveEnable = sel35 & intDrive & (enableReq == ReqMatch);

endmodule

// File: rtl/scratch_window_ctrl.sv
module scratch_window_ctrl
  import swc_pkg::*;
#(
  parameter int RAM_BYTES = 2048,
  parameter int WIN_BYTES = 32,
  parameter int REQ_W = 2,
  parameter int DRIVE_SEL = 2,
  localparam int WIN_W = $clog2(WIN_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                romSwitch,
  input  logic                busSel,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [SwcAddrW-1:0] busAddr,
  input  logic [7:0]          busWdata,
  output logic [7:0]          busRdata,
  input  logic [REQ_W-1:0]    enableReq,
  output logic                diskReset,
  output logic                hdSel,
  output logic                sel35,
  output logic                intDrive,
  output logic                driveEnable
);

  ramStrobe_t       ramStb;
  ctlStrobe_t       ctlStb;
  logic [WIN_W-1:0] winOfs;

  swc_decode #(.WIN_BYTES(WIN_BYTES)) u_decode (
    .busSel   (busSel),
    .busRd    (busRd),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .romSwitch(romSwitch),
    .ramStb   (ramStb),
    .ctlStb   (ctlStb),
    .winOfs   (winOfs)
  );

  swc_datapath #(.RAM_BYTES(RAM_BYTES), .WIN_BYTES(WIN_BYTES)) u_data (
    .clk      (clk),
    .rst      (rst),
    .romSwitch(romSwitch),
    .ramStb   (ramStb),
    .winOfs   (winOfs),
    .wrData   (busWdata),
    .rdData   (busRdata)
  );

  swc_ctlbits #(.REQ_W(REQ_W), .DRIVE_SEL(DRIVE_SEL)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .romSwitch  (romSwitch),
    .ctlStb     (ctlStb),
    .enableReq  (enableReq),
    .hdSel      (hdSel),
    .sel35      (sel35),
    .intDrive   (intDrive),
    .diskReset  (diskReset),
    .driveEnable(driveEnable)
  );

endmodule

// File: rtl/swc_checker.sv
module swc_checker (
  input logic        clk,
  input logic        rst,
  input logic        romSwitch,
  input logic        busSel,
  input logic        busRd,
  input logic        busWr,
  input logic [10:0] busAddr,
  input logic [1:0]  enableReq,
  input logic        diskReset,
  input logic        hdSel,
  input logic        sel35,
  input logic        intDrive,
  input logic        driveEnable
);

  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
    diskReset |=> !diskReset);

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (rst)
    diskReset |-> $past(busSel && busWr && romSwitch && busAddr == 11'h440));

  assert_enable_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (enableReq != 2'd2) |-> !driveEnable);

  assert_rom_low_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !romSwitch |=> (!sel35 && !intDrive));

  assert_head_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(busSel && busRd && !busWr && romSwitch) |=> $stable(hdSel));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busSel && romSwitch) |=> ($stable(sel35) && $stable(intDrive)));

endmodule

bind scratch_window_ctrl swc_checker u_chk (.*);

// File: tb/sim_scratch_window_ctrl.sv
module sim_scratch_window_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        romSwitch = 1'b1;
  logic        busSel = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [10:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [1:0]  enableReq = '0;
  logic [7:0]  busRdata;
  logic        diskReset, hdSel, sel35, intDrive, driveEnable;

  always #4 clk = ~clk;  // 125 MHz

  scratch_window_ctrl u0 (
    .clk(clk), .rst(rst), .romSwitch(romSwitch), .busSel(busSel),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .enableReq(enableReq), .diskReset(diskReset),
    .hdSel(hdSel), .sel35(sel35), .intDrive(intDrive), .driveEnable(driveEnable)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] mm [0:2047];
  int   mPage;
  logic mHd, m35, mInt, mRst;
  logic [7:0] mRd;
  bit   mOn = 0;
  int   o;
  bit   hit, isWr, isRd;

  always @(posedge clk) begin
    if (rst) begin
      mPage = 0; mHd = 0; m35 = 0; mInt = 0; mRst = 0; mRd = 0;
    end else begin
      mRst = 0;
      hit  = busSel && romSwitch && busAddr >= 11'h400 &&
             (busAddr < 11'h500 || (busAddr >= 11'h600 && busAddr < 11'h700));
      o    = int'(busAddr) - 'h400;
      isWr = hit && busWr;
      isRd = hit && busRd && !busWr;
      if (busSel && busRd && !busWr) mRd = 8'h00;
      if (isRd && o >= 'h200 && o < 'h240) mRd = mm[mPage + o % 32];
      if (isWr && o >= 'h200 && o < 'h240) mm[mPage + o % 32] = busWdata;
      if ((isWr || isRd) && o >= 'h220 && o < 'h240) mPage = (mPage + 32) % 2048;
      if ((isWr || isRd) && o == 'h2A0) mPage = 0;
      if (isRd && o >= 'h240 && o < 'h260) mHd = 0;
      if (isRd && o >= 'h260 && o < 'h280) mHd = 1;
      if (isWr && o >= 'h240 && o < 'h260) m35 = 0;
      if (isWr && o >= 'h260 && o < 'h280) m35 = 1;
      if (isWr && o == 'h40) mRst = 1;
      if (isWr && o >= 'h80 && o < 'hA0) mInt = 1;
      if (isWr && o >= 'hC0 && o < 'hE0) mInt = 0;
      if (!romSwitch) begin mPage = 0; m35 = 0; mInt = 0; end
    end
    mOn = 1;
  end

  always @(negedge clk) begin
    if (mOn && !finished) begin
      chk("R2", "busRdata", busRdata, mRd);
      chk("R6", "diskReset", {7'b0, diskReset}, {7'b0, mRst});
      chk("R5", "hdSel", {7'b0, hdSel}, {7'b0, mHd});
      chk("R5", "sel35", {7'b0, sel35}, {7'b0, m35});
      chk("R7", "intDrive", {7'b0, intDrive}, {7'b0, mInt});
      chk("R10", "driveEnable", {7'b0, driveEnable},
          {7'b0, m35 && mInt && enableReq == 2'd2});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(logic s, logic r, logic w, logic [10:0] a, logic [7:0] d);
    @(posedge clk); #1;
    busSel = s; busRd = r; busWr = w; busAddr = a; busWdata = d;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 11'h000, 8'h00);
  endtask

  task automatic rdChk(logic [10:0] a, logic [7:0] exp, string tag);
    drive(1'b1, 1'b1, 1'b0, a, 8'h00);
    idle();
    @(negedge clk);
    chk(tag, "read", busRdata, exp);
  endtask

  task automatic wrOp(logic [10:0] a, logic [7:0] d);
    drive(1'b1, 1'b0, 1'b1, a, d);
    idle();
    @(negedge clk);
  endtask

  task automatic setRom(logic v);
    @(posedge clk); #1;
    romSwitch = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "busRdata", busRdata, 8'h00);
    chk("R1", "flags", {3'b0, diskReset, hdSel, sel35, intDrive, driveEnable}, 8'h00);

    // preload every page with a pattern, advancing on the last byte of each page
    for (int p = 0; p < 64; p++)
      for (int b = 0; b < 32; b++)
        drive(1'b1, 1'b0, 1'b1, (b == 31) ? 11'h63F : 11'(11'h600 + b), pat(p * 32 + b));
    idle();
    rdChk(11'h600, pat(0), "R3");   // 64 advances wrapped to page 0

    // R2: direct window access leaves the page where it is
    rdChk(11'h605, pat(5), "R2");
    rdChk(11'h605, pat(5), "R2");

    // R3: read at old page, then advance
    rdChk(11'h623, pat(3), "R3");
    rdChk(11'h603, pat(35), "R3");

    // R4: write to page-reset offset
    wrOp(11'h6A0, 8'h00);
    rdChk(11'h601, pat(1), "R4");

    // R3: write lands at old page before advance
    wrOp(11'h624, 8'hA5);
    rdChk(11'h604, pat(36), "R3");
    rdChk(11'h6A0, 8'h00, "R4");     // read also resets page, returns zero
    rdChk(11'h604, 8'hA5, "R3");

    // R3: full lap of reads returns to page 0
    for (int k = 0; k < 64; k++) drive(1'b1, 1'b1, 1'b0, 11'h620, 8'h00);
    idle();
    rdChk(11'h600, 8'hA5 == pat(0) ? pat(0) : pat(0), "R3");

    // R5 / R11: head select via reads, data is zero
    rdChk(11'h660, 8'h00, "R11");
    chk("R5", "hdSel set", {7'b0, hdSel}, 8'h01);
    rdChk(11'h645, 8'h00, "R11");
    chk("R5", "hdSel clr", {7'b0, hdSel}, 8'h00);
    rdChk(11'h67F, 8'h00, "R11");
    chk("R5", "hdSel set", {7'b0, hdSel}, 8'h01);

    // R5: 3.5-inch select via writes
    wrOp(11'h670, 8'h00);
    chk("R5", "sel35 set", {7'b0, sel35}, 8'h01);
    wrOp(11'h650, 8'h00);
    chk("R5", "sel35 clr", {7'b0, sel35}, 8'h00);
    wrOp(11'h660, 8'h00);
    chk("R5", "sel35 set", {7'b0, sel35}, 8'h01);
    chk("R5", "hdSel kept", {7'b0, hdSel}, 8'h01);

    // R6: disk-controller reset pulse
    drive(1'b1, 1'b0, 1'b1, 11'h440, 8'h00);
    idle();
    @(negedge clk);
    chk("R6", "pulse high", {7'b0, diskReset}, 8'h01);
    @(negedge clk);
    chk("R6", "pulse low", {7'b0, diskReset}, 8'h00);

    // R7: internal drive enable
    wrOp(11'h490, 8'h00);
    chk("R7", "intDrive set", {7'b0, intDrive}, 8'h01);
    wrOp(11'h4C5, 8'h00);
    chk("R7", "intDrive clr", {7'b0, intDrive}, 8'h00);
    wrOp(11'h480, 8'h00);
    chk("R7", "intDrive set", {7'b0, intDrive}, 8'h01);

    // R10: gated drive enable, same cycle
    @(posedge clk); #1 enableReq = 2'd2;
    @(negedge clk);
    chk("R10", "enable on", {7'b0, driveEnable}, 8'h01);
    @(posedge clk); #1 enableReq = 2'd1;
    @(negedge clk);
    chk("R10", "req 1", {7'b0, driveEnable}, 8'h00);
    @(posedge clk); #1 enableReq = 2'd3;
    @(negedge clk);
    chk("R10", "req 3", {7'b0, driveEnable}, 8'h00);
    @(posedge clk); #1 enableReq = 2'd2;

    // R8: addresses outside the two slices are ignored
    wrOp(11'h5C0, 8'h00);
    wrOp(11'h0C0, 8'h00);
    wrOp(11'h7C0, 8'h00);
    chk("R8", "intDrive kept", {7'b0, intDrive}, 8'h01);
    wrOp(11'h210, 8'h77);
    rdChk(11'h610, pat(16), "R8");
    rdChk(11'h240, 8'h00, "R8");
    chk("R8", "hdSel kept", {7'b0, hdSel}, 8'h01);
    drive(1'b0, 1'b0, 1'b1, 11'h4C0, 8'h00);
    idle();
    @(negedge clk);
    chk("R8", "unselected", {7'b0, intDrive}, 8'h01);
    rdChk(11'h500, 8'h00, "R8");

    // R9: romSwitch low clears pointer and drive bits, ignores accesses
    drive(1'b1, 1'b1, 1'b0, 11'h620, 8'h00);   // page -> 1
    idle();
    setRom(1'b0);
    wrOp(11'h600, 8'h99);
    wrOp(11'h670, 8'h00);
    setRom(1'b1);
    @(negedge clk);
    chk("R9", "sel35", {7'b0, sel35}, 8'h00);
    chk("R9", "intDrive", {7'b0, intDrive}, 8'h00);
    chk("R9", "hdSel kept", {7'b0, hdSel}, 8'h01);
    chk("R10", "enable off", {7'b0, driveEnable}, 8'h00);
    rdChk(11'h600, pat(0), "R9");

    // R1 / R11: reset clears flags, RAM survives
    wrOp(11'h670, 8'h00);
    wrOp(11'h490, 8'h00);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R1", "flags", {3'b0, diskReset, hdSel, sel35, intDrive, driveEnable}, 8'h00);
    chk("R1", "busRdata", busRdata, 8'h00);
    rdChk(11'h607, pat(7), "R11");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule